// File: doc/BRIEF.md
# Phase-Aligned Three-Bank Clock Divider

This block takes one fast reference clock and produces three banks of single-ended clock outputs. All banks come from one shared phase counter, so every output rises on the same reference edge. Bank A runs at the reference rate or at half of it. Banks B and C each run at half or at a quarter of the reference rate. Each bank drives a parameterized number of identical copies.

An active-low reset forces every output low at once. An output enable first passes through a synchronizer. After a fixed, parameterized number of reference edges, all outputs start together. When the enable drops, the outputs drain in a fixed order. Quarter-rate outputs stop first, then half-rate outputs, then reference-rate outputs. Each output stops only where it would fall anyway, so no pulse is ever shortened. The reference-rate path is a gated copy of the reference clock. Its gate changes only while the clock is low. A divide-select change made while running is held back to the next boundary of the quarter-rate period. When the block is integrated, undriven control pins are tied high. That default gives: reset released, enabled, bank A at half rate, banks B and C at quarter rate.

Top module: `clk_bank_divider`

## Requirements
- R1: While `rst_n` is 0, every bit of `out_a`, `out_b` and `out_c` is 0. This holds at once, even during the high half of the reference clock and whatever `en` and the selects are.
- R2: With `rst_n` at 1 and `en` held at 0, every output stays 0.
- R3: Bank A encoding: `sel_a` = 0 makes `out_a` a gated copy of the reference clock (high in the first half of each cycle). `sel_a` = 1 makes it high for one cycle and low for one cycle.
- R4: Banks B and C encoding: select = 0 makes the output high for one cycle and low for one cycle. Select = 1 makes it high for two cycles and low for two cycles.
- R5: If `en` rises between edge n and edge n+1, all outputs are 0 up to cycle n+START_LAT. Every output then goes high in the cycle that begins at edge n+1+START_LAT. That cycle is phase 0 of the shared counter.
- R6: If `en` falls between edge n and edge n+1, let j be the first cycle at or after n+2 that is at phase 1. Outputs keep their normal waveform up to and including cycle j+2 (phase 3). From cycle j+3 on, all outputs are 0. So quarter-rate outputs make their last pulse in phase 1, half-rate outputs in phase 2, and reference-rate outputs in phase 3.
- R7: No shortened pulses. A half-rate high lasts exactly one cycle. A quarter-rate high lasts exactly two cycles. A reference-rate output is never high in the second half of a cycle.
- R8: A select change applied between edge n and edge n+1 takes effect in the first cycle at or after n+1 that is at phase 0. Before that cycle, the old ratio stays in force.
- R9: All bits of one bank output vector always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Output enable, asynchronous to the reference |
| sel_a | input | 1 | Bank A ratio: 0 = x1, 1 = /2 |
| sel_b | input | 1 | Bank B ratio: 0 = /2, 1 = /4 |
| sel_c | input | 1 | Bank C ratio: 0 = /2, 1 = /4 |
| out_a | output | A_FANOUT | Bank A clock copies |
| out_b | output | B_FANOUT | Bank B clock copies |
| out_c | output | C_FANOUT | Bank C clock copies |

## Verification
A select change and a disable can land in the same quarter-rate period. The outcome then depends on whether the phase-0 boundary comes before or after the drain starts. The bench provokes this by dropping `en` and changing all three selects at the same instant. It computes the boundary cycle and the drain cycles separately from the running phase. It then expects the new ratios only in cycles from that boundary up to phase 3 of the drain. All outputs must be 0 afterwards. A second collision is a reset that hits a running bank. It is judged both halfway through a high reference phase and on the restart that follows.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;
   localparam int PH_W = 2;
   typedef logic [PH_W-1:0] phase_t;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARM   = 2'd1,
      ST_RUN   = 2'd2,
      ST_DRAIN = 2'd3
   } seq_state_t;
endpackage

// File: rtl/cdiv_sync.sv
`timescale 1ns/1ps
module cdiv_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cdiv_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cdiv_seq.sv
`timescale 1ns/1ps
module cdiv_seq
   import cdiv_pkg::*;
#(
   parameter int START_LAT   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_s,
   output logic div1,
   output logic q2,
   output logic q4,
   output logic load_sel
);
   localparam int ARM_CYC = START_LAT - SYNC_STAGES;
   localparam int ARM_W   = (ARM_CYC > 2) ? $clog2(ARM_CYC) : 1;

   if (START_LAT < SYNC_STAGES || START_LAT > 6) begin : g_bad_lat
      $error("cdiv_seq: START_LAT must lie in SYNC_STAGES..6");
   end

   seq_state_t       st, st_n;
   phase_t           ph, ph_n;
   logic [ARM_W-1:0] cnt, cnt_n;
   logic             run1_n, run2_n, run4_n;
   logic             gate1;

   always_comb begin
      st_n  = st;
      ph_n  = ph;
      cnt_n = cnt;
      unique case (st)
         ST_IDLE: begin
            ph_n = '0;
            if (en_s) begin
               if (ARM_CYC == 0) st_n = ST_RUN;
               else begin
                  st_n  = ST_ARM;
                  cnt_n = ARM_W'(ARM_CYC - 1);
               end
            end
         end
         ST_ARM: begin
            ph_n = '0;
            if (!en_s)          st_n = ST_IDLE;
            else if (cnt == '0) st_n = ST_RUN;
            else                cnt_n = cnt - 1'b1;
         end
         ST_RUN: begin
            ph_n = ph + 1'b1;
            if (!en_s && ph == phase_t'(1)) st_n = ST_DRAIN;
         end
         ST_DRAIN: begin
            ph_n = ph + 1'b1;
            if (ph == phase_t'(3)) st_n = ST_IDLE;
         end
         default: st_n = ST_IDLE;
      endcase
   end

   // drain stops quarter rate at phase 2, half rate at phase 3, full rate after
   assign run4_n   = (st_n == ST_RUN);
   assign run2_n   = run4_n || (st_n == ST_DRAIN && ph_n == phase_t'(2));
   assign run1_n   = (st_n == ST_RUN) || (st_n == ST_DRAIN);
   assign load_sel = (ph_n == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         ph  <= '0;
         cnt <= '0;
         q2  <= 1'b0;
         q4  <= 1'b0;
      end else begin
         st  <= st_n;
         ph  <= ph_n;
         cnt <= cnt_n;
         q2  <= run2_n & ~ph_n[0];
         q4  <= run4_n & ~ph_n[1];
      end
   end

   // gate changes only while the reference is low
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) gate1 <= 1'b0;
      else        gate1 <= run1_n;
   end

   assign div1 = clk & gate1;

   AST_START_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && $past(st) == ST_ARM) || (st == ST_RUN && $past(st) == ST_IDLE)
      |-> q2 && q4 && gate1); // R5
   AST_QUARTER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DRAIN && $past(st) == ST_RUN) |-> !q4 && q2 && gate1); // R6
   AST_FULL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate1) |-> !q2 && !q4); // R6
   AST_QUARTER_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q4) |=> q4); // R7
   AST_HALF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      q2 |=> !q2); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && $past(st) == ST_IDLE) |-> !q2 && !q4 && !gate1); // R2
endmodule

// File: rtl/cdiv_bank.sv
`timescale 1ns/1ps
module cdiv_bank #(
   parameter int WIDTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_sel,
   input  logic             sel,
   input  logic             src_lo,
   input  logic             src_hi,
   output logic [WIDTH-1:0] out
);
   if (WIDTH < 1) begin : g_bad_width
      $error("cdiv_bank: WIDTH must be at least 1");
   end

   logic sel_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sel_eff <= 1'b1;
      else if (load_sel) sel_eff <= sel;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_copy
      assign out[i] = sel_eff ? src_hi : src_lo;
   end

   AST_SEL_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sel_eff) |-> $past(load_sel)); // R8
endmodule

// File: rtl/clk_bank_divider.sv
`timescale 1ns/1ps
module clk_bank_divider #(
   parameter int A_FANOUT    = 4,
   parameter int B_FANOUT    = 3,
   parameter int C_FANOUT    = 1,
   parameter int START_LAT   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk_ref,
   input  logic                rst_n,
   input  logic                en,
   input  logic                sel_a,
   input  logic                sel_b,
   input  logic                sel_c,
   output logic [A_FANOUT-1:0] out_a,
   output logic [B_FANOUT-1:0] out_b,
   output logic [C_FANOUT-1:0] out_c
);
   logic en_s, div1, q2, q4, load_sel;

   cdiv_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
      .clk(clk_ref), .rst_n(rst_n), .d(en), .q(en_s)
   );

   cdiv_seq #(.START_LAT(START_LAT), .SYNC_STAGES(SYNC_STAGES)) u_seq (
      .clk(clk_ref), .rst_n(rst_n), .en_s(en_s),
      .div1(div1), .q2(q2), .q4(q4), .load_sel(load_sel)
   );

   cdiv_bank #(.WIDTH(A_FANOUT)) u_bank_a (
      .clk(clk_ref), .rst_n(rst_n), .load_sel(load_sel), .sel(sel_a),
      .src_lo(div1), .src_hi(q2), .out(out_a)
   );

   cdiv_bank #(.WIDTH(B_FANOUT)) u_bank_b (
      .clk(clk_ref), .rst_n(rst_n), .load_sel(load_sel), .sel(sel_b),
      .src_lo(q2), .src_hi(q4), .out(out_b)
   );

   cdiv_bank #(.WIDTH(C_FANOUT)) u_bank_c (
      .clk(clk_ref), .rst_n(rst_n), .load_sel(load_sel), .sel(sel_c),
      .src_lo(q2), .src_hi(q4), .out(out_c)
   );

   AST_RESET_QUIET: assert property (@(posedge clk_ref)
      !rst_n |-> out_a == '0 && out_b == '0 && out_c == '0); // R1
endmodule

// File: tb/clk_bank_divider_tb.sv
`timescale 1ns/1ps
module clk_bank_divider_tb;
   localparam int AF = 4, BF = 3, CF = 1, LAT = 4;

   logic clk = 1'b0;
   logic rst_n, en, sel_a, sel_b, sel_c;
   logic [AF-1:0] out_a;
   logic [BF-1:0] out_b;
   logic [CF-1:0] out_c;

   clk_bank_divider #(.A_FANOUT(AF), .B_FANOUT(BF), .C_FANOUT(CF), .START_LAT(LAT)) u_dut (
      .clk_ref(clk), .rst_n(rst_n), .en(en), .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
      .out_a(out_a), .out_b(out_b), .out_c(out_c)
   );

   always #4 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int    cyc;
      logic  a_hi, a_lo, b, c;
      string req;
   } exp_t;

   exp_t exp_q[$];
   int total = 0, bad = 0;
   int start_c = 0, last = 0;
   bit cur_a, cur_b, cur_c;

   task automatic chk(bit ok, string req, string what, int act, int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, expv, cyc);
      end
   endtask

   function automatic exp_t wave(int m, bit sa, bit sb, bit sc, string req);
      exp_t e;
      int k = m - start_c;
      bit h2 = (k % 2) == 0;
      bit h4 = (k % 4) < 2;
      e.cyc  = m;
      e.a_hi = sa ? h2 : 1'b1;
      e.a_lo = sa ? h2 : 1'b0;
      e.b    = sb ? h4 : h2;
      e.c    = sc ? h4 : h2;
      e.req  = req;
      return e;
   endfunction

   function automatic exp_t zero(int m, string req);
      exp_t e;
      e.cyc = m; e.a_hi = 0; e.a_lo = 0; e.b = 0; e.c = 0; e.req = req;
      return e;
   endfunction

   task automatic push(exp_t e);
      exp_q.push_back(e);
      last = e.cyc;
   endtask

   task automatic goto(int c);
      do begin
         @(posedge clk);
         #3;
      end while (cyc < c);
   endtask

   // monitor: samples high half and low half of every cycle
   initial begin
      forever begin
         int   c_now;
         logic [AF-1:0] ah, al;
         logic [BF-1:0] sb;
         logic [CF-1:0] sc;
         exp_t e;
         @(posedge clk);
         #2;
         c_now = cyc;
         ah = out_a;
         #4;
         al = out_a; sb = out_b; sc = out_c;
         chk((ah == '0 || ah == '1) && (al == '0 || al == '1) && (sb == '0 || sb == '1),
             "R9", "bank copies equal", int'(ah), 0);
         while (exp_q.size() > 0 && exp_q[0].cyc < c_now) begin
            e = exp_q.pop_front();
            chk(1'b0, e.req, "expectation never sampled", c_now, e.cyc);
         end
         if (exp_q.size() > 0 && exp_q[0].cyc == c_now) begin
            e = exp_q.pop_front();
            chk(ah[0] == e.a_hi, e.req, $sformatf("bank A high half c%0d", c_now), int'(ah[0]), int'(e.a_hi));
            chk(al[0] == e.a_lo, e.req, $sformatf("bank A low half c%0d", c_now),  int'(al[0]), int'(e.a_lo));
            chk(sb[0] == e.b,    e.req, $sformatf("bank B c%0d", c_now),           int'(sb[0]), int'(e.b));
            chk(sc[0] == e.c,    e.req, $sformatf("bank C c%0d", c_now),           int'(sc[0]), int'(e.c));
         end
      end
   end

   task automatic do_start(bit sa, bit sb, bit sc, int ncyc);
      int n;
      goto(last + 1);
      n = cyc;
      sel_a = sa; sel_b = sb; sel_c = sc;
      cur_a = sa; cur_b = sb; cur_c = sc;
      en = 1'b1;
      start_c = n + 1 + LAT;
      for (int m = n; m < start_c; m++) push(zero(m, "R5"));
      push(wave(start_c, sa, sb, sc, "R5"));
      for (int m = start_c + 1; m < start_c + ncyc; m++) push(wave(m, sa, sb, sc, "R3 R4 R7"));
   endtask

   // disable, optionally changing selects at the same instant
   task automatic do_stop(bit sa, bit sb, bit sc);
      int n, j, e;
      goto(last + 1);
      n = cyc;
      en = 1'b0;
      sel_a = sa; sel_b = sb; sel_c = sc;
      j = n + 2;
      while (((j - start_c) % 4) != 1) j++;
      e = n + 1;
      while (((e - start_c) % 4) != 0) e++;
      for (int m = n; m <= j + 2; m++)
         if (m >= e) push(wave(m, sa, sb, sc, "R6 R8"));
         else        push(wave(m, cur_a, cur_b, cur_c, "R6"));
      for (int m = j + 3; m <= j + 5; m++) push(zero(m, "R6"));
      cur_a = sa; cur_b = sb; cur_c = sc;
   endtask

   task automatic do_change(bit sa, bit sb, bit sc);
      int n, e;
      goto(last + 1);
      n = cyc;
      sel_a = sa; sel_b = sb; sel_c = sc;
      e = n + 1;
      while (((e - start_c) % 4) != 0) e++;
      for (int m = n; m <= e + 7; m++)
         if (m >= e) push(wave(m, sa, sb, sc, "R8"));
         else        push(wave(m, cur_a, cur_b, cur_c, "R8"));
      cur_a = sa; cur_b = sb; cur_c = sc;
   endtask

   task automatic do_reset_hit();
      int n;
      exp_t e;
      goto(last + 1);
      n = cyc;
      e = wave(n, cur_a, cur_b, cur_c, "R1");
      e.a_lo = 0; e.b = 0; e.c = 0;
      push(e);
      push(zero(n + 1, "R1"));
      push(zero(n + 2, "R1"));
      rst_n = 1'b0;
      #0.5;
      chk(clk === 1'b1, "R1", "reference high at probe", int'(clk), 1);
      chk(out_a == '0, "R1", "bank A during reset", int'(out_a), 0);
      chk(out_b == '0, "R1", "bank B during reset", int'(out_b), 0);
      chk(out_c == '0, "R1", "bank C during reset", int'(out_c), 0);
      goto(n + 2);
      rst_n = 1'b1;
      start_c = n + 3 + LAT;
      for (int m = n + 3; m < start_c; m++) push(zero(m, "R5"));
      for (int m = start_c; m < start_c + 8; m++) push(wave(m, cur_a, cur_b, cur_c, "R3 R4 R5"));
   endtask

   initial begin
      #(8 * 100000);
      bad++;
      total++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; en = 1'b0; sel_a = 1'b1; sel_b = 1'b1; sel_c = 1'b1;
      cur_a = 1; cur_b = 1; cur_c = 1;
      goto(2);
      // R1 reset state with the reference high
      chk(out_a == '0 && out_b == '0 && out_c == '0, "R1", "outputs at reset",
          int'({out_a, out_b, out_c}), 0);
      rst_n = 1'b1;
      last = cyc;
      // R2 enable low keeps everything quiet
      for (int m = cyc + 1; m <= cyc + 8; m++) push(zero(m, "R2"));
      // R3 R4 every select combination, start and drain each time
      for (int i = 0; i < 8; i++) begin
         do_start(i[0], i[1], i[2], 12);
         do_stop(i[0], i[1], i[2]);
      end
      // R8 select changes while running
      do_start(1'b0, 1'b0, 1'b0, 6);
      do_change(1'b1, 1'b1, 1'b1);
      do_change(1'b0, 1'b1, 1'b0);
      // disable and select change in the same instant
      do_stop(1'b1, 1'b0, 1'b1);
      do_start(1'b1, 1'b0, 1'b0, 5);
      do_stop(1'b0, 1'b1, 1'b1);
      // R1 reset hits a running bank, then restarts with enable still high
      do_start(1'b0, 1'b1, 1'b0, 7);
      do_reset_hit();
      do_stop(1'b0, 1'b1, 1'b0);
      goto(last + 2);
      chk(exp_q.size() == 0, "R6", "pending expectations", exp_q.size(), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule